// File: doc/BRIEF.md
# Stripe Scan Sequencer for a Parallel 2-D Wavelet Transform

This block produces the read order for a parallel two-dimensional wavelet engine with S processing units that walks an image in vertical stripes. The image is taken to have an extra all-zero column placed at column 0. Each stripe is 2S+1 columns wide. The next stripe begins 2S columns to the right, so each pair of neighbouring stripes shares one column. Inside a stripe the sequencer issues one row per cycle, going from row 0 down to the last row. It then moves to the next stripe. With an image width of R*2S real columns there are R stripes, and the padded columns run from 0 to R*2S.

Every valid cycle carries several outputs: the row index, the base column of the stripe, and the padded column address for each of the 2S+1 lanes. It also drives a per-lane flag that marks the column already read by the previous stripe, and a per-lane flag that marks the zero pad column. Three markers flag the first row of a stripe, the last row of a stripe and the last row of the frame. A single start pulse runs one full frame. When the frame is over, a one-cycle done pulse follows. Pixel storage and filtering are left to the surrounding logic.

Top module: `stripe_scan_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid`, `done` and every flag and marker are 0.
- R2: A `start` sampled high while idle makes the next cycle valid, with row 0 and base column 0.
- R3: Within a stripe, each valid cycle after the first carries the row index one higher than the cycle before it.
- R4: The cycle after the last row (ROWS-1) of a stripe that is not the final one is valid, with row 0 and base column 2S larger.
- R5: Lane k, for k from 0 to 2S, carries column base+k, packed at bits [k*CW +: CW] of `lane_col`.
- R6: Overlap bit 0 is high in every valid cycle of stripes 1 to R-1 and low in stripe 0. Overlap bits 1 to 2S are never high.
- R7: Pad bit 0 is high in every valid cycle of stripe 0 and low elsewhere. Pad bits 1 to 2S are never high.
- R8: `stripe_first` is high exactly on valid cycles with row 0, and `stripe_last` is high exactly on valid cycles with row ROWS-1.
- R9: `frame_last` is high only on the last row of stripe R-1. The next cycle has `valid` low and `done` high for exactly one cycle. A frame lasts ROWS*R valid cycles.
- R10: `start` while a scan is running has no effect on the sequence.
- R11: While idle, `valid`, the lane flags and all markers stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one frame scan when idle |
| valid | output | 1 | Current row segment is valid |
| row | output | RW | Row index of the segment |
| base_col | output | CW | Padded column of lane 0 |
| lane_col | output | (2S+1)*CW | Padded column of each lane, lane k at [k*CW +: CW] |
| overlap | output | 2S+1 | Lane repeats a column of the previous stripe |
| pad_lane | output | 2S+1 | Lane carries the zero pad column |
| stripe_first | output | 1 | First row of a stripe |
| stripe_last | output | 1 | Last row of a stripe |
| frame_last | output | 1 | Last row of the last stripe |
| done | output | 1 | One-cycle pulse after the frame ends |

## Verification
The bench targets four failure points. It checks the row wrap at each stripe boundary, where a design with an off-by-one would skip or repeat a row or step the base by 2S+1 instead of 2S. It watches the first and last stripes, where an overlap or pad flag on the wrong lane or stripe would make the filter drop or double-count the shared column. It checks the end of the frame, where a late or doubled `done`, or a `valid` that stays high, would start a phantom stripe. It also holds `start` high in the middle of a run and asserts reset in the middle of a run; a design that restarted on the mid-run start would jump back to row 0.

// File: rtl/stripe_scan_seq.sv
module stripe_scan_seq #(
  parameter int S       = 2,
  parameter int ROWS    = 4,
  parameter int STRIPES = 3,
  localparam int LANES  = 2*S + 1,
  localparam int STEP   = 2*S,
  localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SW     = (STRIPES > 1) ? $clog2(STRIPES) : 1,
  localparam int CW     = $clog2(STEP*STRIPES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                valid,
  output logic [RW-1:0]       row,
  output logic [CW-1:0]       base_col,
  output logic [LANES*CW-1:0] lane_col,
  output logic [LANES-1:0]    overlap,
  output logic [LANES-1:0]    pad_lane,
  output logic                stripe_first,
  output logic                stripe_last,
  output logic                frame_last,
  output logic                done
);

  logic          busy_q;
  logic [RW-1:0] row_q;
  logic [SW-1:0] stripe_q;
  logic          done_q;

  wire row_end    = (row_q == RW'(ROWS-1));
  wire stripe_end = (stripe_q == SW'(STRIPES-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      row_q    <= '0;
      stripe_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= busy_q && row_end && stripe_end;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          row_q    <= '0;
          stripe_q <= '0;
        end
      end else if (row_end) begin
        row_q <= '0;
        if (stripe_end) busy_q   <= 1'b0;
        else            stripe_q <= stripe_q + 1'b1;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  assign valid        = busy_q;
  assign row          = row_q;
  assign base_col     = CW'(stripe_q) * CW'(STEP);
  assign stripe_first = busy_q && (row_q == '0);
  assign stripe_last  = busy_q && row_end;
  assign frame_last   = busy_q && row_end && stripe_end;
  assign done         = done_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_col[k*CW +: CW] = base_col + CW'(k);
    if (k == 0) begin : g_edge
      assign overlap[k]  = busy_q && (stripe_q != '0);
      assign pad_lane[k] = busy_q && (stripe_q == '0);
    end else begin : g_inner
      assign overlap[k]  = 1'b0;
      assign pad_lane[k] = 1'b0;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && start) |=> (valid && row == '0 && base_col == '0));

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !stripe_last) |=> (valid && row == $past(row) + 1'b1 && $stable(base_col)));

  p_stripe_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stripe_last && !frame_last) |=> (valid && row == '0 && base_col == $past(base_col) + CW'(STEP)));

  p_overlap_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(overlap) && (overlap[LANES-1:1] == '0));

  p_pad_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_lane[0] && overlap[0]) && (pad_lane[0] -> lane_col[CW-1:0] == '0));

  p_frame_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> (done && !valid));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !frame_last) |=> valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (overlap == '0 && pad_lane == '0 && !stripe_first && !stripe_last && !frame_last));

endmodule

// File: tb/tb_stripe_scan_seq.sv
module tb_stripe_scan_seq;
  localparam int S = 2, ROWS = 4, STRIPES = 3;
  localparam int LANES = 2*S + 1, CW = 4, RW = 2, NV = ROWS*STRIPES;

  // expected {row, base column} per valid cycle
  localparam logic [15:0] EXP [0:NV-1] = '{
    16'h0000, 16'h0100, 16'h0200, 16'h0300,
    16'h0004, 16'h0104, 16'h0204, 16'h0304,
    16'h0008, 16'h0108, 16'h0208, 16'h0308};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic valid, stripe_first, stripe_last, frame_last, done;
  logic [RW-1:0] row;
  logic [CW-1:0] base_col;
  logic [LANES*CW-1:0] lane_col;
  logic [LANES-1:0] overlap, pad_lane;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  stripe_scan_seq #(.S(S), .ROWS(ROWS), .STRIPES(STRIPES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .row(row),
    .base_col(base_col), .lane_col(lane_col), .overlap(overlap),
    .pad_lane(pad_lane), .stripe_first(stripe_first), .stripe_last(stripe_last),
    .frame_last(frame_last), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk_idle(input string req);
    chk(valid == 0, req, valid, 0);
    chk(overlap == 0 && pad_lane == 0, req, {overlap, pad_lane}, 0);
    chk(!stripe_first && !stripe_last && !frame_last, req,
        {stripe_first, stripe_last, frame_last}, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(); tick();
    chk_idle("R1 in reset");
    chk(done == 0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    tick();
    chk_idle("R1 after reset");
    chk(done == 0, "R1 done after reset", done, 0);
    tick();
    chk_idle("R11 idle without start");

    start = 1'b1;
    tick();
    for (int i = 0; i < NV; i++) begin
      automatic int er = EXP[i][15:8];
      automatic int eb = EXP[i][7:0];
      automatic int st = i / ROWS;
      start = (i == 1 || i == 5 || i == 6) ? 1'b1 : 1'b0; // R10 mid-run starts
      chk(valid == 1, (i == 0) ? "R2 valid" : "R10 valid", valid, 1);
      chk(row == er, (i % ROWS == 0) ? "R4 row wrap" : "R3 row", row, er);
      chk(base_col == eb, (i == 0) ? "R2 base" : "R4 base", base_col, eb);
      for (int k = 0; k < LANES; k++)
        chk(lane_col[k*CW +: CW] == eb + k, "R5 lane col", lane_col[k*CW +: CW], eb + k);
      chk(overlap == ((st != 0) ? 5'b00001 : 5'b0), "R6 overlap", overlap, (st != 0) ? 1 : 0);
      chk(pad_lane == ((st == 0) ? 5'b00001 : 5'b0), "R7 pad", pad_lane, (st == 0) ? 1 : 0);
      chk(stripe_first == (er == 0), "R8 stripe_first", stripe_first, er == 0);
      chk(stripe_last == (er == ROWS-1), "R8 stripe_last", stripe_last, er == ROWS-1);
      chk(frame_last == (i == NV-1), "R9 frame_last", frame_last, i == NV-1);
      chk(done == 0, "R9 no early done", done, 0);
      tick();
    end
    start = 1'b0;
    chk(valid == 0, "R9 valid drops", valid, 0);
    chk(done == 1, "R9 done pulse", done, 1);
    tick();
    chk(done == 0, "R9 done single", done, 0);
    chk_idle("R11 idle after frame");
    tick();
    chk_idle("R11 still idle");

    start = 1'b1;
    tick();
    start = 1'b0;
    chk(valid == 1 && row == 0 && base_col == 0, "R2 second start", {valid, row, base_col}, 64);
    tick(); tick();
    chk(row == 2, "R3 second run row", row, 2);
    rst_n = 1'b0;
    tick();
    chk_idle("R1 reset mid-run");
    chk(done == 0, "R1 done mid-run reset", done, 0);
    rst_n = 1'b1;
    tick();
    chk_idle("R1 idle after mid-run reset");
    finish_run();
  end
endmodule